// File: doc/BRIEF.md
# Three-Wire Serial Configuration Word Loader

This block takes configuration words over a three-wire serial port: a serial clock, a data line and a load strobe. It routes each complete word into one of four holding registers. Data bits move into a 23-bit shift register on each rising serial clock edge. The most significant bit comes first, so the last bit shifted in is word bit 1. When the load strobe rises, the two lowest word bits (bit 1 and bit 2) pick the destination register and the payload is copied there. The four destinations are a reference-divider register and a counter register for each of a low band and a high band. Each register brings its decoded fields out as parallel outputs and holds them until the next load to that register.

The three serial inputs are asynchronous to the system clock. Each passes through a synchronizer of `SYNC_STAGES` flops, and edges are then found by comparing each synchronized level with its value one cycle earlier. While the load strobe is high the shift register is frozen. A status output stays high from reset until each of the four registers has been written at least once.

Top module: `serial_word_loader`

## Requirements
- R1: Each rising serial clock edge seen while the load strobe is low shifts one data bit into the low end of the 23-bit shift register. The word is sent with bit 23 first and bit 1 last.
- R2: A rising load strobe writes the shift register into exactly one destination, selected by the code {bit 2, bit 1}: 00 selects the low-band reference register, 01 the high-band reference register, 10 the low-band counter register and 11 the high-band counter register. The other three registers keep their values.
- R3: A reference word decodes as follows. Bits 3 and 4 give the 2-bit test select (bit 3 is its LSB). Bits 5 to 18 give the 14-bit reference ratio (bit 5 is its LSB). Bit 19 gives the pump-strength bit. Bits 20 to 23 are ignored.
- R4: A counter word decodes as follows. Bit 4 gives the prescaler select and bit 5 the detector polarity. Bits 6 to 12 give the 7-bit swallow count (bit 6 is its LSB). Bits 13 to 23 give the 11-bit main count (bit 13 is its LSB).
- R5: Bit 3 of a counter word, whether loaded into the low-band or the high-band counter register, sets one shared monitor-select output. Reference word loads leave this output unchanged.
- R6: Serial clock edges that occur while the load strobe is high are ignored and leave the shift register unchanged.
- R7: Reset clears every field output and the monitor-select output to 0 and sets `unconfigured` to 1. `unconfigured` falls once all four registers have been written since reset, and then stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Load strobe (asynchronous) |
| lo_ref_tsel | output | 2 | Low-band reference test select |
| lo_ref_ratio | output | 14 | Low-band reference ratio |
| lo_ref_pump | output | 1 | Low-band pump strength |
| hi_ref_tsel | output | 2 | High-band reference test select |
| hi_ref_ratio | output | 14 | High-band reference ratio |
| hi_ref_pump | output | 1 | High-band pump strength |
| lo_cnt_prsel | output | 1 | Low-band prescaler select |
| lo_cnt_pol | output | 1 | Low-band detector polarity |
| lo_cnt_swal | output | 7 | Low-band swallow count |
| lo_cnt_main | output | 11 | Low-band main count |
| hi_cnt_prsel | output | 1 | High-band prescaler select |
| hi_cnt_pol | output | 1 | High-band detector polarity |
| hi_cnt_swal | output | 7 | High-band swallow count |
| hi_cnt_main | output | 11 | High-band main count |
| mon_sel | output | 1 | Shared monitor select |
| unconfigured | output | 1 | High until all four registers are written |

## Verification
The assertions assume the following about the serial inputs:
- Each serial input level is held for several system clock cycles, so the synchronizers never miss an edge.
- The data line is stable around every serial clock rise.
- Reference ratios and main counts sent to the block are at least 3, since smaller values are prohibited.

The stimulus meets these assumptions in three ways:
- Every serial level is held for at least three system clock cycles.
- Data changes only while the serial clock is low.
- Random ratio and main-count fields below 3 are forced up to 3 before the word is sent.

// File: rtl/swl_pkg.sv
package swl_pkg;
    localparam int WORD_W  = 23;
    localparam int RATIO_W = 14;
    localparam int SWAL_W  = 7;
    localparam int MAIN_W  = 11;
    localparam int DEST_N  = 4;

    // field positions inside the shift register (index = word bit - 1)
    localparam int TSEL_LSB  = 2;
    localparam int RATIO_LSB = 4;
    localparam int PUMP_POS  = RATIO_LSB + RATIO_W;
    localparam int MON_POS   = 2;
    localparam int PRSEL_POS = 3;
    localparam int POL_POS   = 4;
    localparam int SWAL_LSB  = 5;
    localparam int MAIN_LSB  = SWAL_LSB + SWAL_W;

    typedef enum logic [1:0] {
        DST_LO_REF = 2'b00,
        DST_HI_REF = 2'b01,
        DST_LO_CNT = 2'b10,
        DST_HI_CNT = 2'b11
    } dest_e;

    typedef struct packed {
        logic [1:0]         tsel;
        logic [RATIO_W-1:0] ratio;
        logic               pump;
    } ref_fields_t;

    typedef struct packed {
        logic              prsel;
        logic              pol;
        logic [SWAL_W-1:0] swal;
        logic [MAIN_W-1:0] main;
    } cnt_fields_t;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        if (STAGES > 1) pipe_d = {pipe_q[STAGES-2:0], pin};
        else            pipe_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl = pipe_q[STAGES-1];
endmodule

// File: rtl/swl_shifter.sv
module swl_shifter
    import swl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[WORD_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
endmodule

// File: rtl/swl_latch_bank.sv
module swl_latch_bank
    import swl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output ref_fields_t       lo_ref,
    output ref_fields_t       hi_ref,
    output cnt_fields_t       lo_cnt,
    output cnt_fields_t       hi_cnt,
    output logic              mon,
    output logic              unconf,
    output logic [DEST_N-1:0] wr_en
);
    typedef struct packed {
        ref_fields_t       lo_ref;
        ref_fields_t       hi_ref;
        cnt_fields_t       lo_cnt;
        cnt_fields_t       hi_cnt;
        logic              mon;
        logic [DEST_N-1:0] seen;
    } bank_t;

    bank_t st_d, st_q;
    ref_fields_t ref_dec;
    cnt_fields_t cnt_dec;

    genvar g;
    generate
        for (g = 0; g < DEST_N; g++) begin : g_dec
            assign wr_en[g] = load && (word[1:0] == g[1:0]);
        end
    endgenerate

    always_comb begin
        ref_dec.tsel  = word[TSEL_LSB +: 2];
        ref_dec.ratio = word[RATIO_LSB +: RATIO_W];
        ref_dec.pump  = word[PUMP_POS];
        cnt_dec.prsel = word[PRSEL_POS];
        cnt_dec.pol   = word[POL_POS];
        cnt_dec.swal  = word[SWAL_LSB +: SWAL_W];
        cnt_dec.main  = word[MAIN_LSB +: MAIN_W];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en[DST_LO_REF]) st_d.lo_ref = ref_dec;
        if (wr_en[DST_HI_REF]) st_d.hi_ref = ref_dec;
        if (wr_en[DST_LO_CNT]) st_d.lo_cnt = cnt_dec;
        if (wr_en[DST_HI_CNT]) st_d.hi_cnt = cnt_dec;
        if (wr_en[DST_LO_CNT] || wr_en[DST_HI_CNT]) st_d.mon = word[MON_POS];
        st_d.seen = st_q.seen | wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_ref = st_q.lo_ref;
    assign hi_ref = st_q.hi_ref;
    assign lo_cnt = st_q.lo_cnt;
    assign hi_cnt = st_q.hi_cnt;
    assign mon    = st_q.mon;
    assign unconf = ~&st_q.seen;
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
    import swl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_load,
    output logic [1:0]         lo_ref_tsel,
    output logic [RATIO_W-1:0] lo_ref_ratio,
    output logic               lo_ref_pump,
    output logic [1:0]         hi_ref_tsel,
    output logic [RATIO_W-1:0] hi_ref_ratio,
    output logic               hi_ref_pump,
    output logic               lo_cnt_prsel,
    output logic               lo_cnt_pol,
    output logic [SWAL_W-1:0]  lo_cnt_swal,
    output logic [MAIN_W-1:0]  lo_cnt_main,
    output logic               hi_cnt_prsel,
    output logic               hi_cnt_pol,
    output logic [SWAL_W-1:0]  hi_cnt_swal,
    output logic [MAIN_W-1:0]  hi_cnt_main,
    output logic               mon_sel,
    output logic               unconfigured
);
    localparam int PIN_N = 3;

    typedef struct packed {
        logic sclk_prev;
        logic load_prev;
    } edge_t;

    logic [PIN_N-1:0] pins, lvls;
    logic             sclk_lvl, din, ld_lvl;
    logic             sclk_rise, ld_rise, shift_en;
    edge_t            ed_d, ed_q;
    logic [WORD_W-1:0] word;
    logic [DEST_N-1:0] wr_en;
    ref_fields_t       lo_ref, hi_ref;
    cnt_fields_t       lo_cnt, hi_cnt;

    assign pins = {ser_load, ser_dat, ser_clk};

    genvar p;
    generate
        for (p = 0; p < PIN_N; p++) begin : g_sync
            swl_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .pin(pins[p]), .lvl(lvls[p])
            );
        end
    endgenerate

    assign sclk_lvl = lvls[0];
    assign din      = lvls[1];
    assign ld_lvl   = lvls[2];

    always_comb begin
        ed_d.sclk_prev = sclk_lvl;
        ed_d.load_prev = ld_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign sclk_rise = sclk_lvl & ~ed_q.sclk_prev;
    assign ld_rise   = ld_lvl & ~ed_q.load_prev;
    assign shift_en  = sclk_rise & ~ld_lvl;

    swl_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .word(word)
    );

    swl_latch_bank u_bank (
        .clk(clk), .rst_n(rst_n), .load(ld_rise), .word(word),
        .lo_ref(lo_ref), .hi_ref(hi_ref), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
        .mon(mon_sel), .unconf(unconfigured), .wr_en(wr_en)
    );

    assign lo_ref_tsel  = lo_ref.tsel;
    assign lo_ref_ratio = lo_ref.ratio;
    assign lo_ref_pump  = lo_ref.pump;
    assign hi_ref_tsel  = hi_ref.tsel;
    assign hi_ref_ratio = hi_ref.ratio;
    assign hi_ref_pump  = hi_ref.pump;
    assign lo_cnt_prsel = lo_cnt.prsel;
    assign lo_cnt_pol   = lo_cnt.pol;
    assign lo_cnt_swal  = lo_cnt.swal;
    assign lo_cnt_main  = lo_cnt.main;
    assign hi_cnt_prsel = hi_cnt.prsel;
    assign hi_cnt_pol   = hi_cnt.pol;
    assign hi_cnt_swal  = hi_cnt.swal;
    assign hi_cnt_main  = hi_cnt.main;
endmodule

// File: rtl/swl_chk.sv
module swl_chk
    import swl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ld_lvl,
    input logic               shift_en,
    input logic               din,
    input logic [WORD_W-1:0]  word,
    input logic [DEST_N-1:0]  wr_en,
    input logic [RATIO_W-1:0] lo_ref_ratio,
    input logic [MAIN_W-1:0]  hi_cnt_main,
    input logic               mon_sel,
    input logic               unconfigured
);
    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word[0] == $past(din));

    // R6
    frozen_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lvl |=> $stable(word));

    // R2
    lo_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[0] |=> $stable(lo_ref_ratio));

    // R2
    hi_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[3] |=> $stable(hi_cnt_main));

    // R3
    lo_ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |=> lo_ref_ratio == $past(word[RATIO_LSB +: RATIO_W]));

    // R5
    mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en[2] || wr_en[3]) |=> $stable(mon_sel));

    // R7
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unconfigured |=> !unconfigured);
endmodule

bind serial_word_loader swl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ld_lvl(ld_lvl), .shift_en(shift_en),
    .din(din), .word(word), .wr_en(wr_en), .lo_ref_ratio(lo_ref_ratio),
    .hi_cnt_main(hi_cnt_main), .mon_sel(mon_sel), .unconfigured(unconfigured)
);

// File: tb/serial_word_loader_test.sv
module serial_word_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
    logic [1:0]  lo_ref_tsel, hi_ref_tsel;
    logic [13:0] lo_ref_ratio, hi_ref_ratio;
    logic        lo_ref_pump, hi_ref_pump;
    logic        lo_cnt_prsel, lo_cnt_pol, hi_cnt_prsel, hi_cnt_pol;
    logic [6:0]  lo_cnt_swal, hi_cnt_swal;
    logic [10:0] lo_cnt_main, hi_cnt_main;
    logic        mon_sel, unconfigured;

    int errors = 0;
    int checks = 0;
    logic [22:0] lastw [4];
    logic [3:0]  seen;
    logic        exp_mon;

    always #10 clk = ~clk;

    serial_word_loader uut (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic shift_word(input logic [22:0] w);
        for (int i = 22; i >= 0; i--) begin
            ser_dat = w[i];
            tick(3);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(3);
        end
    endtask

    task automatic pulse_load();
        tick(3);
        ser_load = 1'b1;
        tick(6);
        ser_load = 1'b0;
        tick(6);
    endtask

    function automatic void model_load(input logic [22:0] w);
        lastw[w[1:0]] = w;
        seen[w[1:0]]  = 1'b1;
        if (w[1]) exp_mon = w[2];
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R3"}, "lo_ref_tsel",  32'(lo_ref_tsel),  32'(lastw[0][3:2]));
        chk({tag, " R3"}, "lo_ref_ratio", 32'(lo_ref_ratio), 32'(lastw[0][17:4]));
        chk({tag, " R3"}, "lo_ref_pump",  32'(lo_ref_pump),  32'(lastw[0][18]));
        chk({tag, " R3"}, "hi_ref_tsel",  32'(hi_ref_tsel),  32'(lastw[1][3:2]));
        chk({tag, " R3"}, "hi_ref_ratio", 32'(hi_ref_ratio), 32'(lastw[1][17:4]));
        chk({tag, " R3"}, "hi_ref_pump",  32'(hi_ref_pump),  32'(lastw[1][18]));
        chk({tag, " R4"}, "lo_cnt_prsel", 32'(lo_cnt_prsel), 32'(lastw[2][3]));
        chk({tag, " R4"}, "lo_cnt_pol",   32'(lo_cnt_pol),   32'(lastw[2][4]));
        chk({tag, " R4"}, "lo_cnt_swal",  32'(lo_cnt_swal),  32'(lastw[2][11:5]));
        chk({tag, " R4"}, "lo_cnt_main",  32'(lo_cnt_main),  32'(lastw[2][22:12]));
        chk({tag, " R4"}, "hi_cnt_prsel", 32'(hi_cnt_prsel), 32'(lastw[3][3]));
        chk({tag, " R4"}, "hi_cnt_pol",   32'(hi_cnt_pol),   32'(lastw[3][4]));
        chk({tag, " R4"}, "hi_cnt_swal",  32'(hi_cnt_swal),  32'(lastw[3][11:5]));
        chk({tag, " R4"}, "hi_cnt_main",  32'(hi_cnt_main),  32'(lastw[3][22:12]));
        chk({tag, " R5"}, "mon_sel",      32'(mon_sel),      32'(exp_mon));
        chk({tag, " R7"}, "unconfigured", 32'(unconfigured), 32'(~&seen));
    endtask

    function automatic logic [22:0] legalize(input logic [22:0] w);
        logic [22:0] r = w;
        if (!r[1] && r[17:4] < 14'd3)  r[17:4]  = 14'd3;
        if (r[1]  && r[22:12] < 11'd3) r[22:12] = 11'd3;
        return r;
    endfunction

    task automatic send(input logic [22:0] w, input string tag);
        shift_word(w);
        pulse_load();
        model_load(w);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) lastw[i] = '0;
        seen = '0;
        exp_mon = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R7 reset state
        check_all("reset R7");

        // R2 / R3: directed low-band reference word, don't-care bits set
        send({4'hF, 1'b1, 14'd3, 2'b10, 2'b00}, "dir_lo_ref R2");
        // R3: bits 20-23 changed only, outputs unchanged
        send({4'h0, 1'b1, 14'd3, 2'b10, 2'b00}, "dontcare R3");
        // R2: high-band reference with maximum ratio
        send({4'h5, 1'b0, 14'h3FFF, 2'b01, 2'b01}, "dir_hi_ref R2");
        // R4 / R5: low-band counter, LDS = 1
        send({11'd2047, 7'd127, 1'b1, 1'b0, 1'b1, 2'b10}, "dir_lo_cnt R4");
        chk("R7", "unconfigured before 4th dest", 32'(unconfigured), 32'd1);
        // R5: high-band counter clears shared LDS
        send({11'd3, 7'd0, 1'b0, 1'b1, 1'b0, 2'b11}, "dir_hi_cnt R5");
        chk("R7", "configured after all dests", 32'(unconfigured), 32'd0);
        // R5: reference load leaves monitor select unchanged
        send({4'h0, 1'b1, 14'd100, 2'b11, 2'b01}, "ref_keeps_mon R5");

        // R6: clock edges during load high are ignored
        shift_word({4'h0, 1'b0, 14'd777, 2'b01, 2'b00});
        tick(3);
        ser_load = 1'b1;
        tick(6);
        for (int k = 0; k < 5; k++) begin
            ser_dat = 1'b1;
            tick(3);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(3);
        end
        ser_load = 1'b0;
        tick(6);
        pulse_load();
        model_load({4'h0, 1'b0, 14'd777, 2'b01, 2'b00});
        check_all("frozen_shift R6");

        // R1 / R2: random words to random destinations
        for (int n = 0; n < 40; n++) begin
            logic [22:0] w;
            w = legalize(23'($urandom));
            send(w, "random R1");
        end

        // R7: reset clears configuration again
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        for (int i = 0; i < 4; i++) lastw[i] = '0;
        seen = '0;
        exp_mon = 1'b0;
        check_all("re_reset R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule